// File: doc/BRIEF.md
# Programmable Watchdog Timer with Idle Mode

This block watches a software-driven kick input and warns the reset controller when the kick stops. It counts millisecond ticks since the last kick. Every change of the kick level restarts the count, whether the level rises or falls. When the count reaches the selected period with no kick, the block raises a one-clock expiry pulse. The count then starts again from zero.

A 3-bit select chooses the period. Five codes give periods that double from one code to the next, starting at `BASE_TICKS` ticks. With a 1 ms tick and the default `BASE_TICKS` of 400, the periods run from 0.4 s to 6.4 s. The remaining codes put the timer in idle. In idle it never fires, so start-up or debugging can proceed without resets. While the reset-active input is high, the count is held at zero. Supply sensing and the shaping of reset pulses are handled elsewhere.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_ni` is low, `expire_o` is 0 and the count is zero. If `sel_i` is 001 when reset releases, the first pulse comes on the (limit+1)-th rising edge after release, because the select register leaves reset at 000.
- R2: Codes 001, 010, 011, 100 and 101 select limits of BASE_TICKS×1, ×2, ×4, ×8 and ×16 ticks. Each limit is twice the one before it.
- R3: Codes 000, 110 and 111 are idle. In idle, `expire_o` never rises and the count is held at zero.
- R4: A rising or falling transition of `kick_i` clears the count. The input passes through a two-stage synchronizer, so the clear takes effect on the third rising edge after the change. With a tick on every clock, the next pulse comes on edge limit+3.
- R5: With no clear, `expire_o` pulses on the clock edge that accepts the limit-th tick since the last clear.
- R6: `expire_o` is high for exactly one clock. The count restarts from zero, so with a tick on every clock, pulses repeat every `limit` clocks.
- R7: While `rst_act_i` is high, the count is held at zero and `expire_o` stays 0. Counting resumes on the first tick after it falls, and the pulse comes on edge `limit`.
- R8: A change of `sel_i` clears the count on the edge that first sees the new value. With a tick on every clock, the first pulse comes on edge limit+1.
- R9: Only clocks with `tick_i` high advance the count. Without ticks no pulse occurs, and a tick on every other clock doubles the period in clocks.
- R10: A clear has priority over expiry. A kick clear that lands on the edge of the limit-th tick suppresses that pulse, so the next pulse follows a full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one clock wide (nominally once per millisecond) |
| kick_i | input | 1 | Watchdog kick level, asynchronous; each transition restarts the count |
| sel_i | input | 3 | Timeout select: 000/110/111 idle, 001..101 doubling periods |
| rst_act_i | input | 1 | Reset active from the reset controller; holds the timer cleared |
| expire_o | output | 1 | One-clock expiry pulse toward the reset controller |

## Verification
The assertions assume the following about the inputs:
- `BASE_TICKS` is at least 2, so two pulses can never fall on adjacent clocks.
- `tick_i` and `sel_i` are synchronous to `clk_i`.
- `kick_i` may change at any time and is judged only after the synchronizer.

The bench drives every input on the falling clock edge. It holds the kick at a steady level during reset. It draws its random kick, select and reset-active changes rarely enough that full periods still elapse and expiry is exercised.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W   = 3;
  localparam int PERIODS = 5;  // codes 1..PERIODS are timed, the rest idle
  typedef logic [SEL_W-1:0] wdog_sel_t;
  localparam wdog_sel_t SEL_IDLE = '0;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], kick_i};
      hist_q <= sync_q[STAGES-1];
    end
  end

  // either polarity counts as activity
  assign edge_o = sync_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 400,
  parameter int LIM_W      = $clog2(BASE_TICKS * (1 << (PERIODS - 1)) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wdog_sel_t        sel_i,
  output logic [LIM_W-1:0] limit_o,
  output logic             idle_o,
  output logic             chg_o
);
  wdog_sel_t        sel_q;
  logic [LIM_W-1:0] lim_tab [PERIODS];

  for (genvar g = 0; g < PERIODS; g++) begin : g_tab
    assign lim_tab[g] = LIM_W'(BASE_TICKS << g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_IDLE;
    else         sel_q <= sel_i;
  end

  always_comb begin
    limit_o = '0;
    for (int i = 0; i < PERIODS; i++) begin
      if (sel_q == SEL_W'(i + 1)) limit_o = lim_tab[i];
    end
  end

  assign idle_o = (limit_o == '0);
  assign chg_o  = (sel_i != sel_q);

  assert_limit_doubles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_W'(2)) |-> (limit_o == LIM_W'(2 * BASE_TICKS)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int LIM_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             idle_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expire_o
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] last;

  assign last = limit_i - LIM_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == last) begin
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + LIM_W'(1);
        end
      end
    end
  end

  assert_cnt_below_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> (cnt_q < limit_i));
  assert_clear_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !expire_o));
  assert_pulse_one_clock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_expire_needs_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_i));
  assert_idle_count_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS  = 400,
  parameter int SYNC_STAGES = 2,
  localparam int LIM_W      = $clog2(BASE_TICKS * (1 << (PERIODS - 1)) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rst_act_i,
  output logic             expire_o
);
  logic             kick_edge;
  logic             sel_chg;
  logic             idle;
  logic [LIM_W-1:0] limit;
  logic             clr;

  wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  wdog_period_dec #(.BASE_TICKS(BASE_TICKS), .LIM_W(LIM_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .limit_o (limit),
    .idle_o  (idle),
    .chg_o   (sel_chg)
  );

  assign clr = kick_edge | sel_chg | idle | rst_act_i;

  wdog_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (clr),
    .idle_i   (idle),
    .limit_i  (limit),
    .expire_o (expire_o)
  );

  assert_rst_act_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_i |=> !expire_o);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> !expire_o);
  assert_kick_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> !expire_o);
  assert_sel_change_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> !expire_o);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int BASE = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       kick_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       rst_act_i = 1'b0;
  logic       expire_o;

  int checks = 0;
  int fails  = 0;
  int tick_mode = 0;  // 0 always, 1 alternate, 2 random 75%, 3 never
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  wdog_timer #(.BASE_TICKS(BASE)) dut (
    .clk_i, .rst_ni, .tick_i, .kick_i, .sel_i, .rst_act_i, .expire_o
  );

  function automatic int lim_of(input logic [2:0] s);
    if (s >= 3'd1 && s <= 3'd5) return BASE << (s - 3'd1);
    return 0;
  endfunction

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model from the requirements (R4 latency, R5, R7, R8, R10)
  logic       k1 = 0, k2 = 0, k3 = 0;
  logic [2:0] m_sel = 0;
  int         m_cnt = 0;
  logic       m_exp = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k1 = 0; k2 = 0; k3 = 0; m_sel = 0; m_cnt = 0; m_exp = 0;
    end else begin
      int  lim;
      bit  clr;
      lim = lim_of(m_sel);
      clr = rst_act_i || (sel_i != m_sel) || (k2 != k3) || (lim == 0);
      m_exp = 0;
      if (clr) m_cnt = 0;
      else if (tick_i) begin
        if (m_cnt == lim - 1) begin m_cnt = 0; m_exp = 1; end
        else m_cnt = m_cnt + 1;
      end
      k3 = k2; k2 = k1; k1 = kick_i;
      m_sel = sel_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) check_int("R5 model expire_o", int'(expire_o), int'(m_exp));
  end

  initial begin
    forever begin
      @(negedge clk_i);
      case (tick_mode)
        0: tick_i = 1'b1;
        1: tick_i = ~tick_i;
        2: tick_i = (($urandom % 4) != 0);
        default: tick_i = 1'b0;
      endcase
    end
  end

  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!expire_o && n < 2000);
  endtask

  task automatic count_pulses(input int cyc, output int p);
    p = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (expire_o) p++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, p;
    void'($urandom(32'h5eed_1234));
    sel_i = 3'd1;
    repeat (4) @(negedge clk_i);
    check_int("R1 expire_o in reset", int'(expire_o), 0);
    rst_ni = 1'b1;
    count_to_pulse(n);
    check_int("R1 first pulse after reset", n, lim_of(1) + 1);

    // R3 idle codes
    foreach (sel_i[b]) begin end
    for (int c = 0; c < 3; c++) begin
      sel_i = (c == 0) ? 3'd0 : (c == 1) ? 3'd6 : 3'd7;
      count_pulses(400, p);
      check_int("R3 idle pulses", p, 0);
    end

    // R2 / R6 / R8 each timed code
    for (int c = 1; c <= 5; c++) begin
      sel_i = 3'(c);
      count_to_pulse(n);
      check_int("R8 first pulse after select", n, lim_of(3'(c)) + 1);
      count_to_pulse(n);
      check_int("R2 R6 period", n, lim_of(3'(c)));
    end

    sel_i = 3'd1;
    count_to_pulse(n);
    check_int("R8 select down", n, BASE + 1);

    // R4 rising then falling kick
    for (int e = 0; e < 2; e++) begin
      repeat (5) begin @(posedge clk_i); @(negedge clk_i); end
      kick_i = ~kick_i;
      count_to_pulse(n);
      check_int("R4 kick latency", n, BASE + 3);
    end

    // R7 reset active
    rst_act_i = 1'b1;
    count_pulses(60, p);
    check_int("R7 held pulses", p, 0);
    rst_act_i = 1'b0;
    count_to_pulse(n);
    check_int("R7 release latency", n, BASE);

    // R9 alternate ticks and no ticks
    tick_mode = 1;
    count_to_pulse(n);
    count_to_pulse(n);
    check_int("R9 half-rate period", n, 2 * BASE);
    tick_mode = 3;
    count_pulses(100, p);
    check_int("R9 no tick pulses", p, 0);
    tick_mode = 0;
    count_to_pulse(n);

    // R10 kick clear coinciding with expiry edge
    count_to_pulse(n);
    repeat (BASE - 3) begin @(posedge clk_i); @(negedge clk_i); end
    kick_i = ~kick_i;
    count_to_pulse(p);
    check_int("R10 suppressed pulse", (BASE - 3) + p, 2 * BASE);

    // random phase, checked by the model
    tick_mode = 2;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk_i);
      if ($urandom % 500 == 0) sel_i = 3'($urandom % 4 == 0 ? $urandom % 8 : 1 + $urandom % 3);
      if ($urandom % 150 == 0) kick_i = ~kick_i;
      if ($urandom % 300 == 0) rst_act_i = ~rst_act_i;
      if (rst_act_i && ($urandom % 20 == 0)) rst_act_i = 1'b0;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule